// File: doc/BRIEF.md
# Twisted-Pair Collision Indicator with Heartbeat Test

This block produces the single collision signal that a transceiver hands to its network controller. When the twisted-pair port is active, the signal combines four conditions. The first is transmit and receive activity at the same time. The second is a delayed heartbeat pulse after each transmission. The third is an expired jabber timer. The fourth is the heartbeat that is still produced while diagnostic loopback is selected. When the attachment-unit port is selected, the block passes that port's own collision input through instead.

The block runs on the transmit clock. One clock cycle is one bit time, so every delay below is a count of cycles. The jabber timer lives elsewhere and arrives here as a level. Full duplex (`fdx_n` low) tells the block that overlapping transmit and receive is normal traffic and not a collision. Loopback (`lpbk` high) cuts the line receiver out of the overlap check. Selecting full duplex and loopback together is not allowed. In that case the block holds the collision output low and raises an error flag.

All inputs are registered once, so every output follows its inputs by one clock.

Top module: `tp_collision_merge`

## Requirements
- R1: While `rst_n` is low, and on the first sample after reset when all inputs are idle (`fdx_n` high), `col` and `cfg_err` are 0.
- R2: With `tp_sel` high, `fdx_n` high and `lpbk` low, `tx_active` and `rx_active` both high at a rising edge drive `col` high after that edge.
- R3: With `tp_sel` high and `hb_en_n` low, call k the first edge that samples `tx_active` low after it was high. `col` is then high after edges k+HB_DLY through k+HB_DLY+HB_WID-1 (defaults 10 and 10), and the heartbeat contributes nothing else.
- R4: If `hb_en_n` is high at edge k, or `tp_sel` is low there, that transmission produces no heartbeat.
- R5: If `tx_active` is sampled high at any edge k+1 through k+HB_DLY, the pending heartbeat is cancelled. A later falling edge arms a new one.
- R6: With `tp_sel` high and the combination legal, `jabber` high at an edge drives `col` high after it.
- R7: With `fdx_n` low, transmit and receive overlap does not raise `col`. Heartbeat and jabber still do.
- R8: With `lpbk` high (and `fdx_n` high), overlap does not raise `col`, and the heartbeat of R3 is still produced.
- R9: When `fdx_n` is low and `lpbk` is high at an edge, `cfg_err` is 1 after it. If `tp_sel` is high there too, `col` is 0 after it. Otherwise `cfg_err` is 0.
- R10: With `tp_sel` low at an edge, `col` equals `aui_col` from that edge, whatever the transmit, receive and jabber inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one cycle per bit time |
| rst_n | input | 1 | Asynchronous reset, active low |
| tp_sel | input | 1 | 1 = twisted-pair port selected, 0 = attachment-unit port |
| tx_active | input | 1 | Controller transmit enable |
| rx_active | input | 1 | Receive activity on the twisted pair |
| hb_en_n | input | 1 | Heartbeat test enable, active low |
| fdx_n | input | 1 | Full-duplex select, active low |
| lpbk | input | 1 | Diagnostic loopback, active high |
| jabber | input | 1 | Jabber timer expired |
| aui_col | input | 1 | Collision from the attachment-unit receiver |
| col | output | 1 | Collision to the controller |
| cfg_err | output | 1 | Full duplex and loopback selected together |

## Verification
The hardest case to reach is a transmission that restarts on the last cycle of the heartbeat delay. A cycle early or late turns a cancel into a real pulse, or a pulse into a cancel. The bench sweeps the restart offset over every position from one to HB_DLY+2 cycles after the falling edge. Each offset is compared against a behavioural model on every clock. A run of random traffic with short bursts then mixes falls during a running pulse with changes to the enable, duplex and loopback settings.

// File: rtl/tpcol_pkg.sv
package tpcol_pkg;
  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_PULSE = 2'd2
  } hb_state_t;

  // Terminal count of a phase that lasts len cycles.
  function automatic logic at_last(input int unsigned cnt, input int unsigned len);
    return cnt == len - 1;
  endfunction

  // Counter width that holds values 0..max_len.
  function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction
endpackage

// File: rtl/tpcol_sampler.sv
module tpcol_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic tp_sel,
  input  logic tx_active,
  input  logic rx_active,
  input  logic fdx_n,
  input  logic lpbk,
  input  logic jabber,
  input  logic aui_col,
  output logic tp_q,
  output logic tx_q,
  output logic rx_q,
  output logic fdx_n_q,
  output logic lpbk_q,
  output logic jab_q,
  output logic aui_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tp_q    <= 1'b0;
      tx_q    <= 1'b0;
      rx_q    <= 1'b0;
      fdx_n_q <= 1'b1;
      lpbk_q  <= 1'b0;
      jab_q   <= 1'b0;
      aui_q   <= 1'b0;
    end else begin
      tp_q    <= tp_sel;
      tx_q    <= tx_active;
      rx_q    <= rx_active;
      fdx_n_q <= fdx_n;
      lpbk_q  <= lpbk;
      jab_q   <= jabber;
      aui_q   <= aui_col;
    end
  end
endmodule

// File: rtl/tpcol_heartbeat.sv
module tpcol_heartbeat
  import tpcol_pkg::*;
#(
  parameter int unsigned HB_DLY = 10,
  parameter int unsigned HB_WID = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_now,
  input  logic tx_prev,
  input  logic arm_ok,
  output logic hb_on
);
  localparam int unsigned CW = cnt_width(HB_DLY, HB_WID);

  hb_state_t       state;
  logic [CW-1:0]   cnt;
  logic            tx_fall;
  logic            tx_restart;

  assign tx_fall    = tx_prev && !tx_now;
  assign tx_restart = (state == HB_WAIT) && tx_now;
  assign hb_on      = (state == HB_PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= HB_IDLE;
      cnt   <= '0;
    end else if (tx_fall) begin
      state <= arm_ok ? HB_WAIT : HB_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        HB_WAIT: begin
          if (tx_restart) begin
            state <= HB_IDLE;
            cnt   <= '0;
          end else if (at_last(int'(cnt), HB_DLY)) begin
            state <= HB_PULSE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        HB_PULSE: begin
          if (at_last(int'(cnt), HB_WID)) begin
            state <= HB_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= HB_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  // R3: the delay phase hands over to the pulse on its terminal count
  a_r3_wait_to_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HB_WAIT && int'(cnt) == HB_DLY - 1 && !tx_now && !tx_fall) |=> hb_on);

  // R3: the pulse never outlives its width
  a_r3_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    hb_on |-> int'(cnt) < HB_WID);

  // R5: a restart during the delay leaves no pulse behind
  a_r5_restart_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HB_WAIT && tx_now) |=> !hb_on);

  // R4: a fall without permission never starts a delay
  a_r4_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fall && !arm_ok) |=> state == HB_IDLE);
endmodule

// File: rtl/tpcol_merge.sv
module tpcol_merge (
  input  logic tp_q,
  input  logic tx_q,
  input  logic rx_q,
  input  logic fdx_n_q,
  input  logic lpbk_q,
  input  logic jab_q,
  input  logic aui_q,
  input  logic hb_on,
  output logic col,
  output logic cfg_err
);
  logic overlap;
  logic illegal;
  logic tp_col;

  assign illegal = !fdx_n_q && lpbk_q;
  assign overlap = tx_q && rx_q && fdx_n_q && !lpbk_q;
  assign tp_col  = illegal ? 1'b0 : (overlap || hb_on || jab_q);
  assign col     = tp_q ? tp_col : aui_q;
  assign cfg_err = illegal;
endmodule

// File: rtl/tp_collision_merge.sv
module tp_collision_merge #(
  parameter int unsigned HB_DLY = 10,
  parameter int unsigned HB_WID = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tp_sel,
  input  logic tx_active,
  input  logic rx_active,
  input  logic hb_en_n,
  input  logic fdx_n,
  input  logic lpbk,
  input  logic jabber,
  input  logic aui_col,
  output logic col,
  output logic cfg_err
);
  logic tp_q, tx_q, rx_q, fdx_n_q, lpbk_q, jab_q, aui_q;
  logic hb_on;
  logic hb_arm_ok;

  assign hb_arm_ok = tp_sel && !hb_en_n;

  tpcol_sampler u_smp (
    .clk(clk), .rst_n(rst_n),
    .tp_sel(tp_sel), .tx_active(tx_active), .rx_active(rx_active),
    .fdx_n(fdx_n), .lpbk(lpbk), .jabber(jabber), .aui_col(aui_col),
    .tp_q(tp_q), .tx_q(tx_q), .rx_q(rx_q), .fdx_n_q(fdx_n_q),
    .lpbk_q(lpbk_q), .jab_q(jab_q), .aui_q(aui_q)
  );

  tpcol_heartbeat #(.HB_DLY(HB_DLY), .HB_WID(HB_WID)) u_hb (
    .clk(clk), .rst_n(rst_n),
    .tx_now(tx_active), .tx_prev(tx_q), .arm_ok(hb_arm_ok),
    .hb_on(hb_on)
  );

  tpcol_merge u_mrg (
    .tp_q(tp_q), .tx_q(tx_q), .rx_q(rx_q), .fdx_n_q(fdx_n_q),
    .lpbk_q(lpbk_q), .jab_q(jab_q), .aui_q(aui_q), .hb_on(hb_on),
    .col(col), .cfg_err(cfg_err)
  );

  // R2: half-duplex overlap on twisted pair raises collision next cycle
  a_r2_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (tp_sel && tx_active && rx_active && fdx_n && !lpbk) |=> col);

  // R6: jabber expiry raises collision when the setup is legal
  a_r6_jabber: assert property (@(posedge clk) disable iff (!rst_n)
    (tp_sel && jabber && !(!fdx_n && lpbk)) |=> col);

  // R9: illegal setup flags an error and silences the twisted-pair collision
  a_r9_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (tp_sel && !fdx_n && lpbk) |=> (cfg_err && !col));

  // R10: attachment-unit mode is a one-cycle pass-through
  a_r10_aui_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !tp_sel |=> (col == $past(aui_col)));
endmodule

// File: tb/tp_collision_merge_test.sv
module tp_collision_merge_test;
  localparam int DLY = 10;
  localparam int WID = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tp_sel = 1'b0, tx_active = 1'b0, rx_active = 1'b0, hb_en_n = 1'b1;
  logic fdx_n = 1'b1, lpbk = 1'b0, jabber = 1'b0, aui_col = 1'b0;
  logic col, cfg_err;

  int vectors = 0;
  int fails = 0;
  string tag = "R1";
  bit done = 0;

  // behavioural reference
  bit m_prev_tx = 0, m_armed = 0;
  int m_t = 0;
  bit e_col = 0, e_err = 0;

  always #5 clk = ~clk;

  tp_collision_merge #(.HB_DLY(DLY), .HB_WID(WID)) uut (
    .clk(clk), .rst_n(rst_n), .tp_sel(tp_sel), .tx_active(tx_active),
    .rx_active(rx_active), .hb_en_n(hb_en_n), .fdx_n(fdx_n), .lpbk(lpbk),
    .jabber(jabber), .aui_col(aui_col), .col(col), .cfg_err(cfg_err)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev_tx <= 0; m_armed <= 0; m_t <= 0; e_col <= 0; e_err <= 0;
    end else begin
      bit ill, hb, armed;
      int t;
      ill = !fdx_n && lpbk;
      armed = m_armed; t = m_t;
      if (m_prev_tx && !tx_active) begin
        armed = tp_sel && !hb_en_n; t = 0;
      end else if (armed) begin
        if (t < DLY && tx_active) armed = 0;
        else begin
          t = t + 1;
          if (t >= DLY + WID) armed = 0;
        end
      end
      hb = armed && t >= DLY && t < DLY + WID;
      m_armed <= armed; m_t <= t; m_prev_tx <= tx_active;
      e_err <= ill;
      if (tp_sel) e_col <= ill ? 1'b0 : ((tx_active && rx_active && fdx_n && !lpbk) || hb || jabber);
      else        e_col <= aui_col;
    end
  end

  task automatic check();
    vectors++;
    if (col !== e_col || cfg_err !== e_err) begin
      fails++;
      $display("FAIL %s t=%0t col/err actual=%b%b expected=%b%b", tag, $time, col, cfg_err, e_col, e_err);
    end
  endtask

  // advance n cycles; inputs change at negedge, outputs compared there first
  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check();
    end
  endtask

  task automatic burst(int on_len, int off_len, bit with_rx);
    tx_active = 1'b1; rx_active = with_rx;
    run(on_len);
    tx_active = 1'b0; rx_active = 1'b0;
    run(off_len);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (3) @(negedge clk);
    vectors++;
    if (col !== 1'b0 || cfg_err !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset actual=%b%b expected=00", col, cfg_err);
    end
    rst_n = 1'b1;
    run(3);

    // R2 and R4: overlap with heartbeat disabled
    tp_sel = 1'b1;
    tag = "R2"; burst(8, 4, 1'b1);
    tag = "R4"; burst(6, 30, 1'b0);

    // R3: heartbeat after a lone transmission
    hb_en_n = 1'b0;
    tag = "R3"; burst(12, 30, 1'b0);
    tag = "R3"; burst(1, 30, 1'b0);

    // R5: restart swept over every offset around the end of the delay
    tag = "R5";
    for (int off = 1; off <= DLY + 2; off++) begin
      tx_active = 1'b1; run(5);
      tx_active = 1'b0; run(off);
      tx_active = 1'b1; run(3);
      tx_active = 1'b0; run(25);
    end

    // R4: tp_sel low at the fall, then high again
    tag = "R4";
    tx_active = 1'b1; run(4);
    tp_sel = 1'b0; tx_active = 1'b0; run(1);
    tp_sel = 1'b1; run(25);

    // R6: jabber
    tag = "R6";
    jabber = 1'b1; run(6); jabber = 1'b0; run(3);

    // R7: full duplex hides overlap, heartbeat remains
    tag = "R7";
    fdx_n = 1'b0; burst(10, 25, 1'b1);
    jabber = 1'b1; run(3); jabber = 1'b0; run(2);
    fdx_n = 1'b1;

    // R8: loopback hides receive overlap, heartbeat remains
    tag = "R8";
    lpbk = 1'b1; burst(10, 25, 1'b1); lpbk = 1'b0; run(2);

    // R9: illegal combination
    tag = "R9";
    fdx_n = 1'b0; lpbk = 1'b1; jabber = 1'b1;
    burst(6, 25, 1'b1);
    tp_sel = 1'b0; aui_col = 1'b1; run(3); aui_col = 1'b0; tp_sel = 1'b1;
    jabber = 1'b0; fdx_n = 1'b1; lpbk = 1'b0; run(3);

    // R10: attachment-unit pass-through ignores twisted-pair sources
    tag = "R10";
    tp_sel = 1'b0; jabber = 1'b1;
    for (int i = 0; i < 12; i++) begin
      aui_col = i[0]; tx_active = i[1]; rx_active = i[2];
      run(1);
    end
    tx_active = 1'b0; rx_active = 1'b0; jabber = 1'b0; aui_col = 1'b0;
    run(25);

    // random mix of all modes (R3, R5, R7, R8 interplay)
    tag = "R3";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 20) tx_active = ~tx_active;
      rx_active = ($urandom_range(0, 3) == 0);
      jabber    = ($urandom_range(0, 40) == 0);
      aui_col   = $urandom_range(0, 1);
      if (r == 50) hb_en_n = ~hb_en_n;
      if (r == 51) fdx_n   = ~fdx_n;
      if (r == 52) lpbk    = ~lpbk;
      if (r == 53) tp_sel  = ~tp_sel;
      run(1);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule